// File: doc/BRIEF.md
# Dual-Format Conversion Result Port

This block sits between the data converter core and a set of fourteen bidirectional pad cells. It drives the converted 14-bit result to the pads in one of two forms, chosen by a format input. In word format the whole result appears across the fourteen pads, and the pads are driven only while the host holds both its select and read strobes low. In stream format only a few pads stay in use. One pad takes a host-supplied data clock. One carries the result one bit at a time. One forwards the conversion clock. Two more are inputs that choose an external conversion clock and supply it.

Each completed conversion is reported by a one-cycle valid pulse. That pulse captures the result into a holding register and, at the same moment, loads the stream shifter. The host data clock is brought into the system clock domain through a flop chain. Each falling edge moves the stream on by one bit, most significant bit first, so that the host can read each bit on the following rising edge. After the last bit the stream line stays low until a new result arrives.

Top module: `rpt_result_port`

## Requirements
- R1: In word format (fmt_serial=0) with cs_n=0 and rd_n=0, pad_oe is all ones and pad_out[13:0] equals the held result, pad bit 13 carrying the result MSB.
- R2: In word format with cs_n or rd_n high, pad_oe is all zeros.
- R3: The held result takes res_data on a clock edge where res_valid is 1 and keeps its value on every other edge, whatever res_data does.
- R4: In stream format pad_oe equals 14'b00_0000_0000_0110: only pad 1 (stream data) and pad 2 (conversion clock out) are driven, whatever the levels of cs_n and rd_n.
- R5: conv_clk equals pad_in[4] when fmt_serial=1 and pad_in[0]=1, and equals int_cclk in every other case. In stream format pad_out[2] carries conv_clk.
- R6: On the edge that accepts res_valid, the stream line pad_out[1] takes res_data[13].
- R7: Each falling edge of the data clock pad_in[3] in stream format moves the next lower result bit onto pad_out[1], three system clock edges after the pad level falls. Rising edges of the data clock do not move the stream.
- R8: After 14 falling data clock edges following a load, pad_out[1] is 0 and stays 0 through further edges until the next load.
- R9: A load that arrives partway through a stream discards the bits not yet sent and restarts at the new result MSB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fmt_serial | input | 1 | 1 selects stream format, 0 selects word format |
| cs_n | input | 1 | Active-low host select |
| rd_n | input | 1 | Active-low host read strobe |
| res_valid | input | 1 | One-cycle pulse marking a completed conversion |
| res_data | input | 14 | Conversion result, bit 13 is the MSB |
| int_cclk | input | 1 | Internally generated conversion clock |
| pad_in | input | 14 | Levels sensed at the pads: bit 0 clock select, bit 3 data clock, bit 4 external conversion clock |
| pad_out | output | 14 | Values driven to the pads |
| pad_oe | output | 14 | Per-pad output enable, 1 drives the pad |
| conv_clk | output | 1 | Selected conversion clock to the converter core |

## Verification
A stuck or skipped count in the stream shifter shows on pad_out[1] within three system clocks of the next data clock falling edge. The bit seen there is then a neighbouring result bit, or a stray 1 after the fourteenth edge. A holding register that misses or mis-takes a valid pulse appears on the pads at the first word-format read. A wrong enable or a wrong clock-select decode is visible one delta after the controlling input changes, because both paths are combinational from the ports.

// File: rtl/rpt_pkg.sv
package rpt_pkg;
  parameter int unsigned RES_W = 14;

  localparam int unsigned PAD_CSEL   = 0;
  localparam int unsigned PAD_SDATA  = 1;
  localparam int unsigned PAD_CCLKO  = 2;
  localparam int unsigned PAD_DCLK   = 3;
  localparam int unsigned PAD_CCLKI  = 4;

  typedef enum logic {
    FMT_WORD   = 1'b0,
    FMT_STREAM = 1'b1
  } fmt_e;
endpackage

// File: rtl/rpt_rst_sync.sv
module rpt_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_out
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_n_out = chain_q[STAGES-1];
endmodule

// File: rtl/rpt_edge_sync.sv
module rpt_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic level,
  output logic fall
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;
  logic              prev_q;
  logic              prev_d;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_comb sync_d[g] = async_in;
      end else begin : g_rest
        always_comb sync_d[g] = sync_q[g-1];
      end
    end
  endgenerate

  always_comb prev_d = sync_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  assign level = sync_q[STAGES-1];
  assign fall  = prev_q & ~sync_q[STAGES-1];

  // R7: a detected falling edge lasts exactly one system cycle
  a_r7_fall_single: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> !fall);
endmodule

// File: rtl/rpt_cclk_sel.sv
module rpt_cclk_sel #(
  parameter bit EXT_ALLOWED = 1'b1
) (
  input  logic fmt_serial,
  input  logic sel_ext,
  input  logic ext_cclk,
  input  logic int_cclk,
  output logic cclk
);
  generate
    if (EXT_ALLOWED) begin : g_mux
      logic use_ext;
      always_comb begin
        use_ext = fmt_serial & sel_ext;
        cclk    = use_ext ? ext_cclk : int_cclk;
      end
    end else begin : g_fixed
      logic unused_ok;
      always_comb begin
        unused_ok = fmt_serial ^ sel_ext ^ ext_cclk;
        cclk      = int_cclk;
      end
    end
  endgenerate
endmodule

// File: rtl/rpt_ser_shift.sv
module rpt_ser_shift #(
  parameter int unsigned W = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_data,
  input  logic         step,
  output logic         sdo
);
  localparam int unsigned CW = $clog2(W + 1);
  localparam logic [CW-1:0] FULL = CW'(W);

  logic [W-1:0]  shreg_q, shreg_d;
  logic [CW-1:0] left_q, left_d;
  logic          advance;
  logic          upd_en;

  always_comb begin
    advance = step && (left_q != '0);
    upd_en  = load || advance;
    shreg_d = shreg_q;
    left_d  = left_q;
    if (load) begin
      shreg_d = load_data;
      left_d  = FULL;
    end else if (advance) begin
      shreg_d = {shreg_q[W-2:0], 1'b0};
      left_d  = left_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q <= '0;
      left_q  <= '0;
    end else if (upd_en) begin
      shreg_q <= shreg_d;
      left_q  <= left_d;
    end
  end

  assign sdo = shreg_q[W-1];

  // R6: a load puts the new MSB on the stream line
  a_r6_load_msb: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> sdo == $past(load_data[W-1]));
  // R7: one edge consumes exactly one bit
  a_r7_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && step && left_q != '0) |=> left_q == $past(left_q) - 1'b1);
  // R7: without an edge or load the stream does not move
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !step) |=> $stable(shreg_q));
  // R8: once every bit is sent nothing but zeros remains
  a_r8_drained: assert property (@(posedge clk) disable iff (!rst_n)
    (left_q == '0) |-> (shreg_q == '0));
endmodule

// File: rtl/rpt_result_port.sv
module rpt_result_port #(
  parameter int unsigned RES_W      = rpt_pkg::RES_W,
  parameter int unsigned SYNC_DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fmt_serial,
  input  logic             cs_n,
  input  logic             rd_n,
  input  logic             res_valid,
  input  logic [RES_W-1:0] res_data,
  input  logic             int_cclk,
  input  logic [RES_W-1:0] pad_in,
  output logic [RES_W-1:0] pad_out,
  output logic [RES_W-1:0] pad_oe,
  output logic             conv_clk
);
  import rpt_pkg::*;

  localparam logic [RES_W-1:0] STREAM_OE =
    (RES_W'(1) << PAD_SDATA) | (RES_W'(1) << PAD_CCLKO);

  fmt_e             fmt;
  logic             srst_n;
  logic [RES_W-1:0] held_q, held_d;
  logic             dclk_level;
  logic             dclk_fall;
  logic             sdo;
  logic             word_read;

  assign fmt = fmt_e'(fmt_serial);

  rpt_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .arst_n    (rst_n),
    .rst_n_out (srst_n)
  );

  always_comb held_d = res_data;

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)        held_q <= '0;
    else if (res_valid) held_q <= held_d;
  end

  rpt_edge_sync #(.STAGES(SYNC_DEPTH)) u_dclk (
    .clk      (clk),
    .rst_n    (srst_n),
    .async_in (pad_in[PAD_DCLK]),
    .level    (dclk_level),
    .fall     (dclk_fall)
  );

  rpt_ser_shift #(.W(RES_W)) u_shift (
    .clk       (clk),
    .rst_n     (srst_n),
    .load      (res_valid),
    .load_data (res_data),
    .step      (dclk_fall && (fmt == FMT_STREAM)),
    .sdo       (sdo)
  );

  rpt_cclk_sel #(.EXT_ALLOWED(1'b1)) u_cclk (
    .fmt_serial (fmt_serial),
    .sel_ext    (pad_in[PAD_CSEL]),
    .ext_cclk   (pad_in[PAD_CCLKI]),
    .int_cclk   (int_cclk),
    .cclk       (conv_clk)
  );

  always_comb begin
    word_read = !cs_n && !rd_n;
    pad_out   = '0;
    pad_oe    = '0;
    if (fmt == FMT_STREAM) begin
      pad_out[PAD_SDATA] = sdo;
      pad_out[PAD_CCLKO] = conv_clk;
      pad_oe             = STREAM_OE;
    end else begin
      pad_out = held_q;
      pad_oe  = {RES_W{word_read}};
    end
  end

  // R3: the held result only changes on a valid pulse
  a_r3_hold: assert property (@(posedge clk) disable iff (!srst_n)
    !res_valid |=> $stable(held_q));
  // R3: a valid pulse captures the presented result
  a_r3_capture: assert property (@(posedge clk) disable iff (!srst_n)
    res_valid |=> held_q == $past(res_data));
  // R2: pads float in word format unless the host reads
  a_r2_float: assert property (@(posedge clk) disable iff (!srst_n)
    (!fmt_serial && (cs_n || rd_n)) |-> pad_oe == '0);
  // R4: stream format drives only two pads
  a_r4_two_pads: assert property (@(posedge clk) disable iff (!srst_n)
    fmt_serial |-> $countones(pad_oe) == 2);
  // R7: the synchronised data clock level is never unknown after reset
  a_r7_level_known: assert property (@(posedge clk) disable iff (!srst_n)
    !$isunknown(dclk_level));
endmodule

// File: tb/test_rpt_result_port.sv
module test_rpt_result_port;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        fmt_serial, cs_n, rd_n, res_valid, int_cclk;
  logic [13:0] res_data, pad_in, pad_out, pad_oe;
  logic        conv_clk;
  int          nchk = 0;
  int          nerr = 0;

  always #5 clk = ~clk;

  rpt_result_port i_rpt_result_port (
    .clk(clk), .rst_n(rst_n), .fmt_serial(fmt_serial), .cs_n(cs_n),
    .rd_n(rd_n), .res_valid(res_valid), .res_data(res_data),
    .int_cclk(int_cclk), .pad_in(pad_in), .pad_out(pad_out),
    .pad_oe(pad_oe), .conv_clk(conv_clk)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic load(input logic [13:0] v);
    @(negedge clk);
    res_data  = v;
    res_valid = 1'b1;
    @(negedge clk);
    res_valid = 1'b0;
    #1;
  endtask

  task automatic dclk(input logic lvl);
    @(negedge clk);
    pad_in[3] = lvl;
    waitn(3);
  endtask

  function automatic logic [13:0] pat(input int i);
    logic [13:0] v;
    if (i < 14) v = 14'(1) << i;
    else if (i == 14) v = 14'h0000;
    else if (i == 15) v = 14'h3FFF;
    else if (i == 16) v = 14'h2AAA;
    else if (i == 17) v = 14'h1555;
    else v = 14'((i * 2533 + 77) & 16'h3FFF);
    return v;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; fmt_serial = 1'b0; cs_n = 1'b1; rd_n = 1'b1;
    res_valid = 1'b0; res_data = '0; int_cclk = 1'b0; pad_in = 14'h3FFF;
    waitn(3);
    rst_n = 1'b1;
    waitn(4);

    // Reset state: floating pads, zero held result
    chk(32'(pad_oe), 32'h0, "R2 reset oe");
    cs_n = 1'b0; rd_n = 1'b0; #1;
    chk(32'(pad_out), 32'h0, "R1 reset held value");
    chk(32'(pad_oe), 32'h3FFF, "R1 reset read oe");

    // Word format sweep
    for (int i = 0; i < 26; i++) begin
      logic [13:0] v;
      v = pat(i);
      load(v);
      pad_in = ~v;
      for (int c = 0; c < 4; c++) begin
        @(negedge clk);
        cs_n = c[0]; rd_n = c[1]; #1;
        if (c == 0) begin
          chk(32'(pad_oe), 32'h3FFF, "R1 oe");
          chk(32'(pad_out), 32'(v), "R1 data");
        end else begin
          chk(32'(pad_oe), 32'h0, "R2 oe");
        end
      end
      // R3: result input changes without a valid pulse
      @(negedge clk);
      res_data = ~v; cs_n = 1'b0; rd_n = 1'b0;
      waitn(2);
      chk(32'(pad_out), 32'(v), "R3 hold");
    end

    // Stream format enables
    pad_in = 14'h0008;
    fmt_serial = 1'b1;
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      cs_n = c[0]; rd_n = c[1]; #1;
      chk(32'(pad_oe), 32'h0006, "R4 oe");
    end

    // Conversion clock selection
    for (int k = 0; k < 16; k++) begin
      logic expc;
      @(negedge clk);
      fmt_serial = k[3]; pad_in[0] = k[2]; pad_in[4] = k[1]; int_cclk = k[0]; #1;
      expc = (k[3] && k[2]) ? k[1] : k[0];
      chk(32'(conv_clk), 32'(expc), "R5 conv_clk");
      if (k[3]) chk(32'(pad_out[2]), 32'(expc), "R5 pad2");
    end
    @(negedge clk);
    fmt_serial = 1'b1; pad_in = 14'h0008; int_cclk = 1'b0; #1;

    // Stream sweep
    for (int i = 14; i < 22; i++) begin
      logic [13:0] v;
      v = pat(i);
      load(v);
      chk(32'(pad_out[1]), 32'(v[13]), "R6 msb");
      for (int k = 1; k <= 15; k++) begin
        logic e;
        e = (k < 14) ? v[13-k] : 1'b0;
        dclk(1'b0);
        if (k < 14) chk(32'(pad_out[1]), 32'(e), "R7 fall bit");
        else        chk(32'(pad_out[1]), 32'(e), "R8 drained");
        dclk(1'b1);
        chk(32'(pad_out[1]), 32'(e), "R7 rise no move");
      end
    end

    // Restart in mid stream
    load(14'h2C35);
    for (int k = 0; k < 5; k++) begin
      dclk(1'b0);
      dclk(1'b1);
    end
    load(14'h13CA);
    chk(32'(pad_out[1]), 32'h0, "R9 new msb");
    dclk(1'b0);
    chk(32'(pad_out[1]), 32'h1, "R9 new bit12");
    dclk(1'b1);
    load(14'h2000);
    chk(32'(pad_out[1]), 32'h1, "R9 reload msb");

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule